// File: doc/BRIEF.md
# Reflected CRC-32 update unit with selectable data width

This block performs one step of a CRC-32 update. It takes a 32-bit running checksum and a data operand that is 8, 16, 32 or 64 bits wide, and returns the new 32-bit checksum. It serves as the execution stage behind a processor's CRC instruction family. The checksum uses the reflected convention: data bits are consumed least significant first against the generator 0x04C11DB7. The unit inverts neither the accumulator on entry nor the result on exit, so software applies the customary all-ones seed and the final complement itself.

Operands arrive on a valid/ready stream, and results leave on another one. The block holds a single result register. An input beat is taken when `in_valid` and `in_ready` are both high. Its result appears on the output stream at the next clock edge. A result that the consumer has not taken stays on the output, and nothing in it changes, until `out_ready` is high at a clock edge. While a result is held, `in_ready` is low, so a waiting producer must keep its operands stable. When `out_ready` is high, a new beat can be accepted in the same cycle that the held result drains, which gives one operation per cycle.

Top module: `crc32r_unit`

## Requirements
- R1: The update matches a reflected CRC-32 with generator 0x04C11DB7. An 8-bit update of 0x00 into 0xFFFFFFFF gives 0x2DFD1072. A 64-bit update of 0x3837363534333231 into 0xFFFFFFFF, followed by an 8-bit update of 0x39, gives 0x340BC6D9.
- R2: `in_size` selects the operand width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. For every width, the result equals the bit-reversed remainder of (reversed accumulator shifted up by the width) XOR (reversed data shifted up by 32), taken modulo the generator.
- R3: Data bits at or above the selected width have no effect on the result.
- R4: An accepted input beat shows `out_valid` high after exactly one clock edge, with its result on `out_crc`.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and both `out_valid` and `out_crc` hold their values.
- R6: A synchronous active-high `rst` clears `out_valid`. After reset, `in_ready` is high.
- R7: If a result is taken and no new beat is accepted at the same edge, `out_valid` is low after that edge.
- R8: A zero accumulator with zero data gives a zero result for every width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take an operand beat |
| in_acc | input | 32 | Running checksum before the update |
| in_data | input | 64 | Data operand, low bits used |
| in_size | input | 2 | Operand width code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_crc | output | 32 | Updated checksum |

## Verification
The hardest case to reach is a held result. To reach it, the output is stalled with `out_ready` low, and a second operand is offered while the first result waits. The check then confirms two things: the held checksum does not change, and the second operand is taken only on the edge that drains the first. The bench gets there by dropping `out_ready` before it sends a beat, and then keeping a different beat asserted for several cycles. Every width is also compared against an MSB-first long-division model, which shares no structure with the LSB-first network in the design.

// File: rtl/crc32r_pkg.sv
package crc32r_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned N_SIZE = 4;
  localparam int unsigned MIN_W  = 8;
  localparam int unsigned SIZE_W = $clog2(N_SIZE);

  // Generator in MSB-first form
  localparam logic [CRC_W-1:0] GEN_NORMAL = 32'h04C11DB7;

  typedef enum logic [SIZE_W-1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } crc_size_e;

  function automatic logic [CRC_W-1:0] flip32(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // Generator for LSB-first shifting
  localparam logic [CRC_W-1:0] GEN_REFL = flip32(GEN_NORMAL);
endpackage

// File: rtl/crc32r_lane.sv
module crc32r_lane
  import crc32r_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [CRC_W-1:0] acc,
  input  logic [DW-1:0]    data,
  output logic [CRC_W-1:0] crc
);
  // Unrolled LSB-first shift network for one operand width
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = acc;
    for (int i = 0; i < DW; i++) begin
      fb = c[0] ^ data[i];
      c  = (c >> 1) ^ (fb ? GEN_REFL : '0);
    end
    crc = c;
  end
endmodule

// File: rtl/crc32r_core.sv
module crc32r_core
  import crc32r_pkg::*;
(
  input  logic [CRC_W-1:0]  acc,
  input  logic [DATA_W-1:0] data,
  input  logic [SIZE_W-1:0] size,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] lane_out [N_SIZE];

  for (genvar k = 0; k < N_SIZE; k++) begin : g_lane
    localparam int unsigned LW = MIN_W << k;
    crc32r_lane #(.DW(LW)) i_lane (
      .acc  (acc),
      .data (data[LW-1:0]),
      .crc  (lane_out[k])
    );
  end

  assign crc = lane_out[size];
endmodule

// File: rtl/crc32r_stage.sv
module crc32r_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign up_ready = !vld_q || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (up_ready) begin
      vld_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/crc32r_unit.sv
module crc32r_unit
  import crc32r_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_acc,
  input  logic [63:0] in_data,
  input  logic [1:0]  in_size,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_crc
);
  logic [CRC_W-1:0] next_crc;

  crc32r_core i_core (
    .acc  (in_acc),
    .data (in_data),
    .size (in_size),
    .crc  (next_crc)
  );

  crc32r_stage #(.W(CRC_W)) i_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (next_crc),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_crc)
  );
endmodule

// File: rtl/crc32r_unit_chk.sv
module crc32r_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_acc,
  input logic [63:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_crc
);
  assert_accept_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_crc)));

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_drain_empties_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  assert_zero_in_zero_out_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_acc == '0 && in_data == '0) |=> (out_crc == '0));
endmodule

bind crc32r_unit crc32r_unit_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_acc    (in_acc),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_crc   (out_crc)
);

// File: tb/test_crc32r_unit.sv
module test_crc32r_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_acc;
  logic [63:0] in_data;
  logic [1:0]  in_size;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_crc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  crc32r_unit i_crc32r_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_data(in_data), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc)
  );

  // Row layout: {use_exp, size, acc, data, exp}
  localparam int NV = 12;
  localparam logic [130:0] VEC [NV] = '{
    {1'b1, 2'b00, 32'hFFFFFFFF, 64'h0,                  32'h2DFD1072},
    {1'b1, 2'b00, 32'h0,        64'h0,                  32'h0},
    {1'b1, 2'b01, 32'h0,        64'h0,                  32'h0},
    {1'b1, 2'b10, 32'h0,        64'h0,                  32'h0},
    {1'b1, 2'b11, 32'h0,        64'h0,                  32'h0},
    {1'b0, 2'b00, 32'h12345678, 64'hA5,                 32'h0},
    {1'b0, 2'b01, 32'hFFFFFFFF, 64'hBEEF,               32'h0},
    {1'b0, 2'b01, 32'h00000001, 64'h8000,               32'h0},
    {1'b0, 2'b10, 32'hDEADBEEF, 64'hCAFEF00D,           32'h0},
    {1'b0, 2'b10, 32'h80000000, 64'h00000001,           32'h0},
    {1'b0, 2'b11, 32'hFFFFFFFF, 64'h0123456789ABCDEF,   32'h0},
    {1'b0, 2'b11, 32'h0F0F0F0F, 64'hFFFFFFFFFFFFFFFF,   32'h0}
  };

  // MSB-first long division of the bit-reversed operands
  function automatic logic [31:0] model(input logic [1:0] sz, input logic [31:0] a,
                                        input logic [63:0] d);
    int n = 8 << sz;
    int len = 32 + n;
    logic [31:0] r = '0;
    logic [31:0] o;
    for (int i = 0; i < len; i++) begin
      int  p = len - 1 - i;
      logic b = 1'b0;
      logic top;
      if (p >= n)  b ^= a[31 - (p - n)];
      if (p >= 32) b ^= d[n - 1 - (p - 32)];
      top = r[31];
      r = {r[30:0], b};
      if (top) r ^= 32'h04C11DB7;
    end
    for (int i = 0; i < 32; i++) o[i] = r[31 - i];
    return o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] s, input logic [31:0] a, input logic [63:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_size = s; in_acc = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 out_valid after accept", {31'b0, out_valid}, 32'd1);
    r = out_crc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2, h;
    rst = 1'b1; in_valid = 1'b0; in_acc = '0; in_data = '0; in_size = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R6 out_valid after reset", {31'b0, out_valid}, 32'd0);
    chk("R6 in_ready after reset", {31'b0, in_ready}, 32'd1);

    // Table walk: R1 known values, R2 width selection, R8 zero case
    for (int i = 0; i < NV; i++) begin
      logic [130:0] v = VEC[i];
      logic [31:0] e;
      e = v[130] ? v[31:0] : model(v[129:128], v[127:96], v[95:32]);
      run_op(v[129:128], v[127:96], v[95:32], r1);
      chk(v[130] ? "R1/R8 known value" : "R2 width vs model", r1, e);
    end

    // R1: chained check-string update
    run_op(2'b11, 32'hFFFFFFFF, 64'h3837363534333231, r1);
    run_op(2'b00, r1, 64'h39, r2);
    chk("R1 chained string", r2, 32'h340BC6D9);

    // R3: upper data bits ignored
    run_op(2'b00, 32'hA1B2C3D4, 64'hFFFFFFFFFFFFFF5A, r1);
    chk("R3 byte ignores upper", r1, model(2'b00, 32'hA1B2C3D4, 64'h5A));
    run_op(2'b01, 32'hA1B2C3D4, 64'h123456789ABC1234, r1);
    chk("R3 half ignores upper", r1, model(2'b01, 32'hA1B2C3D4, 64'h1234));
    run_op(2'b10, 32'hA1B2C3D4, 64'hDEADBEEF00C0FFEE, r1);
    chk("R3 word ignores upper", r1, model(2'b10, 32'hA1B2C3D4, 64'h00C0FFEE));

    // R7: drained with no new beat
    @(negedge clk);
    chk("R7 out_valid drops", {31'b0, out_valid}, 32'd0);

    // R5: back-pressure hold
    out_ready = 1'b0;
    run_op(2'b10, 32'h11111111, 64'h22222222, r1);
    h = model(2'b10, 32'h11111111, 64'h22222222);
    chk("R5 first result", r1, h);
    in_valid = 1'b1; in_size = 2'b11; in_acc = 32'h33333333; in_data = 64'h4444444455555555;
    repeat (3) @(negedge clk);
    chk("R5 in_ready low while held", {31'b0, in_ready}, 32'd0);
    chk("R5 out_valid held", {31'b0, out_valid}, 32'd1);
    chk("R5 out_crc held", out_crc, h);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 second result after drain", out_crc, model(2'b11, 32'h33333333, 64'h4444444455555555));
    chk("R4 second valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R7 empty after drain", {31'b0, out_valid}, 32'd0);

    // R6: reset while a result is held
    out_ready = 1'b0;
    run_op(2'b00, 32'h0, 64'h1, r1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R6 reset clears held", {31'b0, out_valid}, 32'd0);
    chk("R6 in_ready after reset", {31'b0, in_ready}, 32'd1);
    out_ready = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule